// File: doc/BRIEF.md
# Receive Self-Test Pattern Checker

This block checks one receive channel's decoded character stream against a known pseudo-random test pattern. Each accepted character has an 8-bit value, a data/command flag and a strobe. Once self-test is switched on, the checker lets the first character pass unchecked and then hunts for the loop's start character. From that point it compares every character against a locally generated sequence. For each character it returns a 3-bit status code, and a loop boundary is marked with a pass or fail code.

A running count of mismatches in excess of matches guards the compare. When errors dominate, the checker abandons the comparison, re-arms the sequence at the start character and hunts again. A flag that says the receive PLL is locked to the reference clock, rather than to line data, suspends checking for the characters it marks.

Top module: `rx_bist_checker`

## Requirements
- R1: After a synchronous reset, `stat_vld` is 0 and `stat_code` is 101.
- R2: While `bist_en` is low, no status is produced (`stat_vld` stays 0) and the checker state is cleared. When `bist_en` rises again the checker restarts from the unchecked first-character step.
- R3: With `bist_en` high, the first accepted character after enable reports 101 (start) and is not compared. The hunt for the start character begins with the next character.
- R4: An accepted character that arrives with `pll_on_ref` high, in any enabled state, reports 101 and leaves the sequence position, the error count and the state unchanged.
- R5: While hunting, the start character (value 0x00, command flag 0) reports 000 and begins comparison. Any other character reports 111.
- R6: The expected sequence starts at position 0 with the start character. Position 1 is value 0x01. Each later value is the previous value shifted left by one, with bit 0 set to b7^b5^b4^b3 of the previous value. A position carries command flag 1 exactly when value bits [7:5] are all 1. After position LOOP_LEN-1 the sequence returns to position 0.
- R7: A correctly matched character that is not the last in the loop reports 000 if its command flag is 0 and 001 if it is 1.
- R8: A character whose value or flag differs from the expected one, and that is not the last in the loop, reports 110.
- R9: The character at position LOOP_LEN-1 reports 010 if it matches and 100 if it does not. The next expected character is then the start character.
- R10: The error count rises by one on each mismatch and falls by one on each match, never below zero. The mismatch that brings it to ABORT_DIFF (default 16) returns the checker to hunting, with the sequence at position 0 and the count cleared.
- R11: `stat_vld` is high for exactly one cycle, in the cycle after each character accepted while enabled, and the code 011 is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_en | input | 1 | Self-test enable for this channel |
| chr_vld | input | 1 | A decoded character is present this cycle |
| chr_data | input | 8 | Decoded character value |
| chr_cmd | input | 1 | Character is a command character |
| pll_on_ref | input | 1 | Receive PLL is tracking the reference clock |
| stat_vld | output | 1 | Status code valid for the previous character |
| stat_code | output | 3 | Per-character status code |

## Verification
Every status code is due in the first cycle after the clock edge that samples its character. The bench drives each character at a falling edge and reads the outputs two time units after the next rising edge, so each result is checked in that cycle.

Enabling takes one clock edge with no character before the first character reports start. The reference model in the bench advances its expected state when it drives a character, not when it reads the result. A status that turns up with no queued expectation is reported as a failure. This catches output while the checker is disabled, and also duplicated pulses.

// File: rtl/rx_bist_pkg.sv
package rx_bist_pkg;

    typedef enum logic [2:0] {
        ST_DATA_OK   = 3'b000,
        ST_CMD_OK    = 3'b001,
        ST_LAST_GOOD = 3'b010,
        ST_RSVD      = 3'b011,
        ST_LAST_BAD  = 3'b100,
        ST_START     = 3'b101,
        ST_ERROR     = 3'b110,
        ST_WAIT      = 3'b111
    } bist_stat_e;

    typedef enum logic [1:0] {
        M_OFF,
        M_START,
        M_HUNT,
        M_RUN
    } bist_mode_e;

    typedef struct packed {
        logic       cmd;
        logic [7:0] data;
    } bist_char_t;

    localparam logic [7:0] PAT_SEED = 8'h01;
    localparam bist_char_t START_CHAR = '{cmd: 1'b0, data: 8'h00};

    // All-zero state stands for the start character; the shift register never reaches it otherwise.
    function automatic logic [7:0] pat_step(input logic [7:0] s);
        if (s == 8'h00)
            return PAT_SEED;
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic bist_char_t pat_char(input logic [7:0] s);
        bist_char_t c;
        c.data = s;
        c.cmd  = (s != 8'h00) && (&s[7:5]);
        return c;
    endfunction

endpackage

// File: rtl/rx_bist_pattern.sv
module rx_bist_pattern
    import rx_bist_pkg::*;
#(
    parameter int LOOP_LEN = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rearm,
    input  logic       advance,
    output bist_char_t exp_char,
    output logic       is_last
);
    localparam int IDX_W = $clog2(LOOP_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LOOP_LEN - 1);

    logic [7:0]       pat_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            pat_q <= 8'h00;
            idx_q <= '0;
        end else if (advance) begin
            if (idx_q == LAST_IDX) begin
                pat_q <= 8'h00;
                idx_q <= '0;
            end else begin
                pat_q <= pat_step(pat_q);
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign exp_char = pat_char(pat_q);
    assign is_last  = (idx_q == LAST_IDX);
endmodule

// File: rtl/rx_bist_diff_cnt.sv
module rx_bist_diff_cnt #(
    parameter int ABORT_DIFF = 16,
    parameter int DIFF_W     = $clog2(ABORT_DIFF + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              bad,
    input  logic              good,
    output logic [DIFF_W-1:0] cnt,
    output logic              at_edge
);
    localparam logic [DIFF_W-1:0] EDGE_VAL = DIFF_W'(ABORT_DIFF - 1);

    logic [DIFF_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (bad)
            cnt_q <= cnt_q + 1'b1;
        else if (good && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign cnt     = cnt_q;
    assign at_edge = (cnt_q == EDGE_VAL);
endmodule

// File: rtl/rx_bist_ctrl.sv
module rx_bist_ctrl
    import rx_bist_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bist_en,
    input  logic       chr_vld,
    input  bist_char_t chr_in,
    input  logic       pll_on_ref,
    input  bist_char_t exp_char,
    input  logic       is_last,
    input  logic       at_edge,
    output logic       rearm,
    output logic       advance,
    output logic       cnt_bad,
    output logic       cnt_good,
    output logic       cnt_clear,
    output logic       stat_vld,
    output logic [2:0] stat_code
);
    bist_mode_e mode_q, mode_n;
    bist_stat_e code_n, code_q;
    logic       sv_n, sv_q;
    logic       match;

    assign match = (chr_in == exp_char);

    always_comb begin
        mode_n    = mode_q;
        code_n    = code_q;
        sv_n      = 1'b0;
        rearm     = 1'b0;
        advance   = 1'b0;
        cnt_bad   = 1'b0;
        cnt_good  = 1'b0;
        cnt_clear = 1'b0;
        if (!bist_en) begin
            mode_n    = M_OFF;
            rearm     = 1'b1;
            cnt_clear = 1'b1;
        end else begin
            unique case (mode_q)
                M_OFF: begin
                    mode_n    = M_START;
                    rearm     = 1'b1;
                    cnt_clear = 1'b1;
                end
                M_START: begin
                    if (chr_vld) begin
                        sv_n   = 1'b1;
                        code_n = ST_START;
                        if (!pll_on_ref)
                            mode_n = M_HUNT;
                    end
                end
                M_HUNT: begin
                    if (chr_vld) begin
                        sv_n = 1'b1;
                        if (pll_on_ref) begin
                            code_n = ST_START;
                        end else if (chr_in == START_CHAR) begin
                            code_n  = ST_DATA_OK;
                            advance = 1'b1;
                            mode_n  = M_RUN;
                        end else begin
                            code_n = ST_WAIT;
                        end
                    end
                end
                M_RUN: begin
                    if (chr_vld) begin
                        sv_n = 1'b1;
                        if (pll_on_ref) begin
                            code_n = ST_START;
                        end else if (match) begin
                            cnt_good = 1'b1;
                            advance  = 1'b1;
                            if (is_last)
                                code_n = ST_LAST_GOOD;
                            else if (exp_char.cmd)
                                code_n = ST_CMD_OK;
                            else
                                code_n = ST_DATA_OK;
                        end else begin
                            code_n  = is_last ? ST_LAST_BAD : ST_ERROR;
                            cnt_bad = 1'b1;
                            if (at_edge) begin
                                rearm     = 1'b1;
                                cnt_clear = 1'b1;
                                mode_n    = M_HUNT;
                            end else begin
                                advance = 1'b1;
                            end
                        end
                    end
                end
                default: mode_n = M_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_OFF;
            code_q <= ST_START;
            sv_q   <= 1'b0;
        end else begin
            mode_q <= mode_n;
            code_q <= code_n;
            sv_q   <= sv_n;
        end
    end

    assign stat_vld  = sv_q;
    assign stat_code = code_q;
endmodule

// File: rtl/rx_bist_checker.sv
module rx_bist_checker
    import rx_bist_pkg::*;
#(
    parameter int LOOP_LEN   = 64,
    parameter int ABORT_DIFF = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bist_en,
    input  logic       chr_vld,
    input  logic [7:0] chr_data,
    input  logic       chr_cmd,
    input  logic       pll_on_ref,
    output logic       stat_vld,
    output logic [2:0] stat_code
);
    localparam int DIFF_W = $clog2(ABORT_DIFF + 1);

    bist_char_t        chr_in;
    bist_char_t        exp_char;
    logic              is_last, at_edge;
    logic              rearm, advance, cnt_bad, cnt_good, cnt_clear;
    logic [DIFF_W-1:0] diff_cnt;

    assign chr_in = '{cmd: chr_cmd, data: chr_data};

    rx_bist_pattern #(.LOOP_LEN(LOOP_LEN)) u_pat (
        .clk      (clk),
        .rst      (rst),
        .rearm    (rearm),
        .advance  (advance),
        .exp_char (exp_char),
        .is_last  (is_last)
    );

    rx_bist_diff_cnt #(.ABORT_DIFF(ABORT_DIFF), .DIFF_W(DIFF_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (cnt_clear),
        .bad     (cnt_bad),
        .good    (cnt_good),
        .cnt     (diff_cnt),
        .at_edge (at_edge)
    );

    rx_bist_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bist_en    (bist_en),
        .chr_vld    (chr_vld),
        .chr_in     (chr_in),
        .pll_on_ref (pll_on_ref),
        .exp_char   (exp_char),
        .is_last    (is_last),
        .at_edge    (at_edge),
        .rearm      (rearm),
        .advance    (advance),
        .cnt_bad    (cnt_bad),
        .cnt_good   (cnt_good),
        .cnt_clear  (cnt_clear),
        .stat_vld   (stat_vld),
        .stat_code  (stat_code)
    );
endmodule

// File: rtl/rx_bist_checker_sva.sv
module rx_bist_checker_sva #(
    parameter int ABORT_DIFF = 16,
    parameter int DIFF_W     = $clog2(ABORT_DIFF + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bist_en,
    input logic              chr_vld,
    input logic              pll_on_ref,
    input logic              stat_vld,
    input logic [2:0]        stat_code,
    input logic [DIFF_W-1:0] diff_cnt
);
    p_no_rsvd_r11: assert property (@(posedge clk) disable iff (rst)
        stat_vld |-> stat_code != 3'b011);

    p_vld_cause_r11: assert property (@(posedge clk) disable iff (rst)
        stat_vld |-> ($past(chr_vld) && $past(bist_en)));

    p_quiet_off_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(bist_en) |-> !stat_vld);

    p_pll_start_r4: assert property (@(posedge clk) disable iff (rst)
        (chr_vld && pll_on_ref && bist_en && $past(bist_en)) |=> (stat_vld && stat_code == 3'b101));

    p_diff_bound_r10: assert property (@(posedge clk) disable iff (rst)
        diff_cnt < DIFF_W'(ABORT_DIFF));
endmodule

bind rx_bist_checker rx_bist_checker_sva #(.ABORT_DIFF(ABORT_DIFF), .DIFF_W(DIFF_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .bist_en    (bist_en),
    .chr_vld    (chr_vld),
    .pll_on_ref (pll_on_ref),
    .stat_vld   (stat_vld),
    .stat_code  (stat_code),
    .diff_cnt   (diff_cnt)
);

// File: tb/sim_rx_bist_checker.sv
`timescale 1ns/1ps
module sim_rx_bist_checker;
    localparam int LOOP  = 48;
    localparam int ABORT = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bist_en = 1'b0;
    logic       chr_vld = 1'b0;
    logic [7:0] chr_data = 8'h00;
    logic       chr_cmd = 1'b0;
    logic       pll_on_ref = 1'b0;
    logic       stat_vld;
    logic [2:0] stat_code;

    always #5 clk = ~clk;

    rx_bist_checker #(.LOOP_LEN(LOOP), .ABORT_DIFF(ABORT)) u0 (
        .clk(clk), .rst(rst), .bist_en(bist_en), .chr_vld(chr_vld),
        .chr_data(chr_data), .chr_cmd(chr_cmd), .pll_on_ref(pll_on_ref),
        .stat_vld(stat_vld), .stat_code(stat_code)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_cmd_seen = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] code;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    // Reference model: 0 off, 1 first char, 2 hunting, 3 comparing
    int         m_mode = 0;
    logic [7:0] m_pat  = 8'h00;
    int         m_idx  = 0;
    int         m_diff = 0;

    function automatic logic m_cmd_of(input logic [7:0] v);
        return (v != 8'h00) && (v[7:5] == 3'b111);
    endfunction

    task automatic m_advance();
        if (m_idx == LOOP - 1) begin
            m_pat = 8'h00;
            m_idx = 0;
        end else begin
            if (m_pat == 8'h00) m_pat = 8'h01;
            else m_pat = {m_pat[6:0], m_pat[7] ^ m_pat[5] ^ m_pat[4] ^ m_pat[3]};
            m_idx++;
        end
    endtask

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic c, input logic p, input string tag);
        exp_t e;
        bit   push = 1'b0;
        e.tag = tag;
        case (m_mode)
            1: begin push = 1'b1; e.code = 3'b101; if (!p) m_mode = 2; end
            2: begin
                push = 1'b1;
                if (p) e.code = 3'b101;
                else if (d == 8'h00 && !c) begin e.code = 3'b000; m_mode = 3; m_advance(); end
                else e.code = 3'b111;
            end
            3: begin
                push = 1'b1;
                if (p) e.code = 3'b101;
                else begin
                    logic ec;
                    logic last;
                    ec   = m_cmd_of(m_pat);
                    last = (m_idx == LOOP - 1);
                    if (d == m_pat && c == ec) begin
                        e.code = last ? 3'b010 : (ec ? 3'b001 : 3'b000);
                        if (ec && !last) n_cmd_seen++;
                        if (m_diff > 0) m_diff--;
                        m_advance();
                    end else begin
                        e.code = last ? 3'b100 : 3'b110;
                        m_diff++;
                        if (m_diff == ABORT) begin
                            m_diff = 0; m_pat = 8'h00; m_idx = 0; m_mode = 2;
                        end else m_advance();
                    end
                end
            end
            default: ;
        endcase
        if (push) sb_q.push_back(e);
        chr_vld = 1'b1; chr_data = d; chr_cmd = c; pll_on_ref = p;
        @(negedge clk);
        chr_vld = 1'b0; pll_on_ref = 1'b0;
    endtask

    task automatic send_good(input string tag);
        send(m_pat, m_cmd_of(m_pat), 1'b0, tag);
    endtask

    task automatic send_bad(input string tag);
        send(m_pat ^ 8'h01, m_cmd_of(m_pat), 1'b0, tag);
    endtask

    task automatic set_en(input logic v);
        bist_en = v;
        if (v && m_mode == 0) begin
            m_mode = 1; m_pat = 8'h00; m_idx = 0; m_diff = 0;
        end
        if (!v) m_mode = 0;
        @(negedge clk);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && stat_vld) begin
                if (sb_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R2/R11: actual unexpected status %b expected none", stat_code);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.tag, stat_code, e.code);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(100000 * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 vld", {2'b00, stat_vld}, 3'b000);
        check("R1 code", stat_code, 3'b101);

        // R2: characters while disabled give no status
        send(8'h00, 1'b0, 1'b0, "R2");
        send(8'h33, 1'b0, 1'b0, "R2");

        set_en(1'b1);
        send(8'h44, 1'b0, 1'b1, "R4 start pll");
        send(8'h55, 1'b0, 1'b0, "R3 first char");
        send(8'h00, 1'b0, 1'b1, "R4 hunt pll");
        send(8'h12, 1'b0, 1'b0, "R5 junk");
        send(8'h00, 1'b1, 1'b0, "R5 cmd zero");
        send(8'h00, 1'b0, 1'b0, "R5 start char");

        for (int i = 1; i < LOOP; i++) send_good("R6/R7/R9 loop1");
        for (int i = 0; i < LOOP - 1; i++) send_good("R6/R7 loop2");
        send_bad("R9 last bad");

        for (int i = 0; i < 3; i++) send_good("R10 saturate");
        send(8'h00, 1'b0, 1'b1, "R4 run pll");
        send_good("R4 run after pll");
        for (int i = 0; i < ABORT - 1; i++) send_bad("R8/R10 errors");
        send_good("R10 recover");
        send_bad("R10 near");
        send_bad("R10 abort");
        send(8'h37, 1'b0, 1'b0, "R10 hunt after abort");
        send(8'h00, 1'b0, 1'b0, "R10 resync");
        for (int i = 1; i < 10; i++) send_good("R7 after resync");

        set_en(1'b0);
        send_good("R2 off");
        send(8'h00, 1'b0, 1'b0, "R2 off");
        set_en(1'b1);
        send(8'h00, 1'b0, 1'b0, "R2 re-enable first");
        send(8'h00, 1'b0, 1'b0, "R2 re-enable start");
        send_good("R6 after re-enable");

        repeat (4) @(negedge clk);
        check("R11 queue drained", 3'(sb_q.size() > 7 ? 7 : sb_q.size()), 3'd0);
        if (n_cmd_seen == 0) $display("note: no command positions in this loop length");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule